// File: doc/BRIEF.md
# Sphere detector level expander

This block grows one partial path of a real-valued sphere-detector search tree by one or more levels at a time. Given a parent path (the symbols already fixed for the upper levels), its accumulated metric, the current squared search radius and a pair of levels (the level the parent reached and the level to stop at), it lists every combination of symbols for the levels in between. For each resulting child it writes the full child path and its accumulated metric to an external child buffer, at an index counted up from a supplied base.

The metric is built up step by step. The parent's metric is the starting value. Each newly added row of the upper-triangular matrix adds the square of that row's weighted distance from the unconstrained centre vector. A parent whose metric has already reached the radius is pruned: each of its children is written with the all-ones "infinite" metric, with no arithmetic done. The triangular matrix and the centre vector are fixed-point constants. They are loaded ahead of time and stay steady while a request runs. Sorting and selecting among children is left to the logic that reads the buffer.

Top module: `sphere_expander`

## Requirements
- R1: While reset is held, and after it is released with no request made, `wr_en` and `done` are low.
- R2: A request from level `src_lvl` down to level `dst_lvl` writes exactly Q^(src_lvl−dst_lvl) children. Their buffer indices are `base_idx`, `base_idx`+1, and so on, with child ordinal i written at `base_idx`+i in ascending order.
- R3: Level L is held in path bits [(L−1)·log2(Q) +: log2(Q)] as a symbol index i, whose value is 2i−(Q−1). In a child path, levels at or above `src_lvl` copy the parent. Each new level `dst_lvl`+d takes base-Q digit d of the child ordinal, so `dst_lvl` takes the least significant digit. Levels below `dst_lvl` are zero.
- R4: For a parent not pruned, a child's metric equals the parent metric plus, for every new level L, ((Σ over k ≥ L−1 of r[L−1][k]·((2s_k−(Q−1))·2^CF − c_k))²) shifted right by SHIFT. Entries of r below the diagonal have no effect.
- R5: A computed metric saturates at 2^MW−2, so a child that is not pruned never carries the infinite code.
- R6: When `parent_metric` ≥ `radius`, every child is written with metric 2^MW−1, one child per clock cycle. The first write appears one cycle after the request is captured.
- R7: When the parent is not pruned, the write for child i appears (src_lvl−dst_lvl)·(i+1) cycles after the clock edge that captures `start`.
- R8: `done` pulses for one cycle together with the last child write. A request with `src_lvl` ≤ `dst_lvl` writes nothing and pulses `done` one cycle after capture.
- R9: A `start` raised while a request is in progress is ignored, and the running request completes with its own captured parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture a new request when idle |
| r_flat | input | N·N·RW | Triangular matrix, entry (j,k) at bits ((j·N+k)·RW) |
| centre | input | N·CW | Centre vector, entry k at bits (k·CW), CF fraction bits |
| parent_path | input | N·log2(Q) | Parent symbol indices by level |
| parent_metric | input | MW | Accumulated metric of the parent |
| radius | input | MW | Current squared radius |
| src_lvl | input | clog2(N+2) | Lowest level already fixed in the parent (N+1 for the root) |
| dst_lvl | input | clog2(N+2) | Lowest level to fill in |
| base_idx | input | IW | Buffer index of child 0 |
| wr_en | output | 1 | Child write strobe |
| wr_idx | output | IW | Child buffer index |
| wr_path | output | N·log2(Q) | Child symbol path |
| wr_metric | output | MW | Child metric, all ones when pruned |
| done | output | 1 | Last child written, or empty request finished |

## Verification
The results come at fixed times. When the parent is not pruned, one child appears every (src_lvl−dst_lvl) cycles, the first that many cycles after `start` is captured. A pruned parent gives one child per cycle. An empty request gives `done` after one cycle. The bench counts clock edges from the edge that captures `start` and stamps every write and `done` with that count as it samples on the falling edge. It then compares each stamp with the cycle the timing rule predicts, and the payload with metrics worked out from the arithmetic rule. A request raised mid-run must leave every stamp and value of the first request unchanged.

// File: rtl/sphere_expander.sv
module sphere_expander #(
  parameter int N     = 4,
  parameter int Q     = 4,
  parameter int RW    = 12,
  parameter int CW    = 12,
  parameter int CF    = 4,
  parameter int SHIFT = 12,
  parameter int MW    = 24,
  parameter int IW    = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [N*N*RW-1:0]       r_flat,
  input  logic [N*CW-1:0]         centre,
  input  logic [N*$clog2(Q)-1:0]  parent_path,
  input  logic [MW-1:0]           parent_metric,
  input  logic [MW-1:0]           radius,
  input  logic [$clog2(N+2)-1:0]  src_lvl,
  input  logic [$clog2(N+2)-1:0]  dst_lvl,
  input  logic [IW-1:0]           base_idx,
  output logic                    wr_en,
  output logic [IW-1:0]           wr_idx,
  output logic [N*$clog2(Q)-1:0]  wr_path,
  output logic [MW-1:0]           wr_metric,
  output logic                    done
);
  localparam int LQ   = $clog2(Q);
  localparam int LW   = $clog2(N+2);
  localparam int CNTW = LQ*N + 1;
  localparam int DFW  = ((CW > LQ+1+CF) ? CW : LQ+1+CF) + 1;
  localparam int DW   = RW + DFW + $clog2(N) + 1;
  localparam int SQW  = 2*DW;
  localparam logic [MW-1:0] INF = '1;

  logic              run_q, prune_q, empty_q;
  logic [N*LQ-1:0]   pp_q;
  logic [MW-1:0]     pm_q, acc_q;
  logic [LW-1:0]     src_q, dst_q, row_q;
  logic [IW-1:0]     base_q;
  logic [CNTW-1:0]   cnt_q, last_q;

  logic [N*LQ-1:0]          kid;
  logic signed [DW-1:0]     dot;
  logic signed [SQW-1:0]    sq;
  logic [SQW:0]             sum;
  logic [MW-1:0]            msat;
  logic                     last_row, last_kid;

  always_comb begin
    kid = '0;
    for (int p = 0; p < N; p++) begin
      if (p >= int'(src_q) - 1)
        kid[p*LQ +: LQ] = pp_q[p*LQ +: LQ];
      else if (p >= int'(dst_q) - 1)
        kid[p*LQ +: LQ] = LQ'(cnt_q >> (LQ*(p - int'(dst_q) + 1)));
    end
  end

  always_comb begin
    logic signed [DFW-1:0] dv;
    logic signed [RW-1:0]  rv;
    logic signed [CW-1:0]  cv;
    dot = '0;
    for (int k = 0; k < N; k++) begin
      rv = r_flat[(int'(row_q)*N + k)*RW +: RW];
      cv = centre[k*CW +: CW];
      dv = DFW'(2*int'(kid[k*LQ +: LQ]) - (Q-1));
      dv = (dv <<< CF) - DFW'(cv);
      if (k >= int'(row_q))
        dot = dot + DW'(rv) * DW'(dv);
    end
  end

  assign sq       = SQW'(dot) * SQW'(dot);
  assign sum      = (SQW+1)'(acc_q) + (SQW+1)'(unsigned'(sq) >> SHIFT);
  assign msat     = (sum >= (SQW+1)'(INF)) ? INF - MW'(1) : sum[MW-1:0];
  assign last_row = (row_q == dst_q - LW'(1));
  assign last_kid = (cnt_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; prune_q <= 1'b0; empty_q <= 1'b0;
      pp_q <= '0; pm_q <= '0; acc_q <= '0;
      src_q <= '0; dst_q <= '0; row_q <= '0; base_q <= '0;
      cnt_q <= '0; last_q <= '0;
      wr_en <= 1'b0; wr_idx <= '0; wr_path <= '0; wr_metric <= '0; done <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      if (!run_q) begin
        if (start) begin
          run_q   <= 1'b1;
          prune_q <= parent_metric >= radius;
          empty_q <= src_lvl <= dst_lvl;
          pp_q    <= parent_path;
          pm_q    <= parent_metric;
          acc_q   <= parent_metric;
          src_q   <= src_lvl;
          dst_q   <= dst_lvl;
          row_q   <= src_lvl - LW'(2);
          base_q  <= base_idx;
          cnt_q   <= '0;
          last_q  <= (CNTW'(1) << (LQ*(int'(src_lvl) - int'(dst_lvl)))) - CNTW'(1);
        end
      end else if (empty_q) begin
        done  <= 1'b1;
        run_q <= 1'b0;
      end else if (prune_q || last_row) begin
        wr_en     <= 1'b1;
        wr_idx    <= base_q + IW'(cnt_q);
        wr_path   <= kid;
        wr_metric <= prune_q ? INF : msat;
        cnt_q     <= cnt_q + CNTW'(1);
        row_q     <= src_q - LW'(2);
        acc_q     <= pm_q;
        if (last_kid) begin
          done  <= 1'b1;
          run_q <= 1'b0;
        end
      end else begin
        row_q <= row_q - LW'(1);
        acc_q <= msat;
      end
    end
  end

  assert_inf_on_prune_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && prune_q |-> wr_metric == INF);
  assert_no_false_inf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !prune_q |-> wr_metric != INF);
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_idx == $past(wr_idx) + IW'(1));
  assert_done_with_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !empty_q |-> wr_en && !run_q);
endmodule

// File: tb/sim_sphere_expander.sv
`timescale 1ns/1ps
module sim_sphere_expander;
  localparam int N = 4, Q = 4, RW = 12, CW = 12, CF = 4, SHIFT = 12, MW = 24, IW = 10;
  localparam longint INF = (64'd1 << MW) - 1;
  localparam int NT = 5;
  localparam int T_SRC[NT]  = '{5, 4, 5, 3, 4};
  localparam int T_DST[NT]  = '{4, 2, 1, 1, 2};
  localparam int T_PATH[NT] = '{8'h00, 8'h80, 8'h00, 8'hD0, 8'hC0};
  localparam int T_PM[NT]   = '{10, 200, 0, 16777210, 100};
  localparam int T_RAD[NT]  = '{1000000, 500, 16777215, 16777215, 100};
  localparam int T_BASE[NT] = '{0, 20, 100, 700, 900};
  localparam int CEN[N]     = '{5, -21, 37, -8};

  logic clk = 0, rst_n = 0, start = 0;
  logic [N*N*RW-1:0] r_flat;
  logic [N*CW-1:0] centre;
  logic [7:0] parent_path = '0;
  logic [MW-1:0] parent_metric = '0, radius = '0;
  logic [2:0] src_lvl = '0, dst_lvl = '0;
  logic [IW-1:0] base_idx = '0;
  logic wr_en, done;
  logic [IW-1:0] wr_idx;
  logic [7:0] wr_path;
  logic [MW-1:0] wr_metric;

  sphere_expander u0 (.clk, .rst_n, .start, .r_flat, .centre, .parent_path, .parent_metric,
    .radius, .src_lvl, .dst_lvl, .base_idx, .wr_en, .wr_idx, .wr_path, .wr_metric, .done);

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, ncap = 0, done_cyc = 0, c0 = 0;
  bit done_seen = 0;
  int cap_idx[256], cap_path[256], cap_cyc[256];
  longint cap_met[256];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (wr_en && ncap < 256) begin
      cap_idx[ncap] = int'(wr_idx); cap_path[ncap] = int'(wr_path);
      cap_met[ncap] = longint'(wr_metric); cap_cyc[ncap] = cyc; ncap++;
    end
    if (done) begin done_seen = 1; done_cyc = cyc; end
  end

  function automatic int rval(int j, int k);
    if (k < j) return 77;
    if (k == j) return 40 - 4*j;
    return ((j*5 + k*3) % 11) - 5;
  endfunction

  function automatic int sym_of(int path, int p);
    return (path >> (2*p)) & 3;
  endfunction

  function automatic int kid_path(int src, int dst, int ppath, int i);
    int v = 0;
    for (int p = 0; p < N; p++) begin
      if (p >= src - 1) v |= sym_of(ppath, p) << (2*p);
      else if (p >= dst - 1) v |= ((i >> (2*(p - dst + 1))) & 3) << (2*p);
    end
    return v;
  endfunction

  function automatic longint kid_metric(int src, int dst, int path, longint pm);
    longint acc = pm, dot;
    for (int j = src - 2; j >= dst - 1; j--) begin
      dot = 0;
      for (int k = j; k < N; k++)
        dot += longint'(rval(j, k)) * longint'((2*sym_of(path, k) - (Q-1))*(1 << CF) - CEN[k]);
      acc += (dot*dot) >> SHIFT;
      if (acc > INF - 1) acc = INF - 1;
    end
    return acc;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int t, input bit interfere);
    int src = T_SRC[t], dst = T_DST[t], w = 0, nk, l;
    bit pr = T_PM[t] >= T_RAD[t];
    longint em;
    @(negedge clk);
    ncap = 0; done_seen = 0;
    src_lvl = 3'(src); dst_lvl = 3'(dst); parent_path = 8'(T_PATH[t]);
    parent_metric = MW'(T_PM[t]); radius = MW'(T_RAD[t]); base_idx = IW'(T_BASE[t]);
    start = 1; c0 = cyc;
    @(negedge clk); start = 0;
    if (interfere) begin
      repeat (2) @(negedge clk);
      start = 1; src_lvl = 3'd5; dst_lvl = 3'd1; base_idx = '0; parent_metric = '0; parent_path = '1;
      @(negedge clk); start = 0;
    end
    while (!done_seen && w < 5000) begin @(negedge clk); w++; end
    if (!done_seen) chk("R8", "watchdog done", 0, 1);
    @(negedge clk);
    if (src <= dst) begin
      chk("R8", "empty writes", ncap, 0);
      chk("R8", "empty done cycle", done_cyc - c0 - 1, 1);
      return;
    end
    l = src - dst;
    nk = 1 << (2*l);
    chk("R2", "child count", ncap, nk);
    for (int i = 0; i < nk && i < ncap; i++) begin
      chk(interfere ? "R9" : "R2", "index", cap_idx[i], T_BASE[t] + i);
      chk(interfere ? "R9" : "R3", "path", cap_path[i], kid_path(src, dst, T_PATH[t], i));
      em = pr ? INF : kid_metric(src, dst, kid_path(src, dst, T_PATH[t], i), longint'(T_PM[t]));
      chk(pr ? "R6" : (T_PM[t] > 1000000 ? "R5" : "R4"), "metric", cap_met[i], em);
      chk(pr ? "R6" : "R7", "write cycle", cap_cyc[i] - c0 - 1, pr ? i + 1 : l*(i + 1));
    end
    if (ncap > 0) chk("R8", "done with last write", done_cyc, cap_cyc[ncap-1]);
  endtask

  initial begin
    for (int j = 0; j < N; j++)
      for (int k = 0; k < N; k++)
        r_flat[(j*N + k)*RW +: RW] = RW'(rval(j, k));
    for (int k = 0; k < N; k++) centre[k*CW +: CW] = CW'(CEN[k]);
    repeat (3) @(negedge clk);
    chk("R1", "wr_en in reset", wr_en, 0);
    chk("R1", "done in reset", done, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1", "wr_en idle", wr_en, 0);
    chk("R1", "done idle", done, 0);
    for (int t = 0; t < NT; t++) run_case(t, 0);
    src_lvl = 3'd2; dst_lvl = 3'd2;
    begin : empty_case
      @(negedge clk);
      ncap = 0; done_seen = 0; start = 1; c0 = cyc;
      @(negedge clk); start = 0;
      repeat (3) @(negedge clk);
      chk("R8", "empty writes", ncap, 0);
      chk("R8", "empty done seen", done_seen, 1);
      chk("R8", "empty done cycle", done_cyc - c0 - 1, 1);
    end
    run_case(1, 1);
    repeat (5) @(negedge clk);
    chk("R9", "no extra run", ncap, 16);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule